// File: doc/BRIEF.md
# Dual-Rate LED Blink and Dimming Engine

This block generates two independent blink waveforms and routes them to eight open-drain LED pins. Each waveform, or channel, has an 8-bit rate value that stretches its period and an 8-bit duty value that sets how long the LED stays lit in each period. A slow channel makes a visible blink. A fast channel with a chosen duty value acts as a brightness control, because the eye averages the on-time. Every pin has a 2-bit source code. The code keeps the pin released, holds it low, or makes it follow one of the two channels.

The block advances on a single-cycle tick enable that comes from a fixed time base, nominally 152 × 256 ticks per second. One channel step takes (rate + 1) ticks, and a full period is 256 steps. A channel period therefore lasts (rate + 1) / 152 seconds. The configuration values are plain inputs that are decoded elsewhere. Each channel takes a new rate or duty value only when its 8-bit phase counter wraps, so a period that is already running is never cut short. The pins only pull low or release. A registered copy of the pad levels is returned on its own port, so pins that are left released can be read as general-purpose inputs.

Top module: `blinkDimmer`

## Requirements
- R1: While `rstN` is low, `pullLow` is all zeros. After reset both phase counters start at 0 and the active values are rate 0 and duty 80h, until the first wrap loads the inputs. For example, with source code 10 and the tick held low, a pin reads lit right after reset, and the first lit run lasts 128 ticks.
- R2: A channel's phase counter advances once every (rate + 1) cycles in which `tickEn` is high, and wraps from 255 to 0. The period is therefore 256 × (rate + 1) ticks, with exactly one rising edge of a following pin per period when the duty value is non-zero. While `tickEn` is low, with `ledSel` unchanged, `pullLow` does not change.
- R3: A pin that follows a channel is driven low (`pullLow` = 1) while the channel's phase is below its active duty value. That gives duty × (rate + 1) lit ticks per period. A duty value of 0 never lights the pin. Every pin that selects the same channel shows the same level.
- R4: LED i takes its source code from `ledSel[2i+1:2i]`. Code 00 releases the pin, 01 drives it low, 10 follows channel 0 (`rate0`/`duty0`), and 11 follows channel 1 (`rate1`/`duty1`). The low byte of `ledSel` therefore covers LED0 to LED3, and the high byte covers LED4 to LED7.
- R5: A change of a duty input takes effect at the next wrap of that channel's phase counter. The lit run that is already in progress keeps the old length.
- R6: A change of a rate input takes effect at the next wrap of that channel's phase counter. The lit run that is already in progress keeps the old step length.
- R7: The pins are open-drain, so `pullLow` = 1 means drive low and 0 means release. `padLevel` equals `padIn` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Single-cycle time-base tick |
| rate0 | input | 8 | Channel 0 step length minus one |
| duty0 | input | 8 | Channel 0 lit phases per period |
| rate1 | input | 8 | Channel 1 step length minus one |
| duty1 | input | 8 | Channel 1 lit phases per period |
| ledSel | input | 16 | 2-bit source code per LED, LED0 in the lowest bits |
| padIn | input | 8 | Sensed pad levels |
| pullLow | output | 8 | Per-pin pull-down enable; 1 sinks current (LED lit) |
| padLevel | output | 8 | Registered pad levels |

## Verification
The internal state is only phase counters, step dividers and held rate and duty values, so every fault in it shows up as lit-time counts or run lengths on `pullLow`. A phase counter that is wrong shifts the rising edges or changes how many occur within one period. A divider or held rate value that is wrong stretches every lit run by a whole factor of (rate + 1). A held value that reloads at the wrong moment changes the length of the run that is already in progress, so that error appears within a single period. A failure to clear the state on reset appears as an unlit pin, or as a first run other than 128 ticks, straight after release.

// File: rtl/blinkPkg.sv
package blinkPkg;
  localparam int CH_COUNT = 2;

  typedef enum logic [1:0] {
    SEL_OFF = 2'b00,
    SEL_ON  = 2'b01,
    SEL_CH0 = 2'b10,
    SEL_CH1 = 2'b11
  } ledSrc_e;

  typedef struct packed {
    logic                run;
    logic [CH_COUNT-1:0] reload;
  } chanStrobe_t;
endpackage

// File: rtl/blinkCtrl.sv
module blinkCtrl
  import blinkPkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8,
  parameter logic [PSC_W-1:0] DEF_PSC = '0
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic [CH_COUNT-1:0][PSC_W-1:0] pscCfg,
  output logic [CH_COUNT-1:0][CNT_W-1:0] phase,
  output chanStrobe_t strobe
);
  localparam logic [CNT_W-1:0] PHASE_LAST = {CNT_W{1'b1}};

  logic runQ;
  logic [CH_COUNT-1:0] reloadVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runQ <= 1'b0;
    else       runQ <= 1'b1;
  end

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    logic [PSC_W-1:0] divCnt;
    logic [PSC_W-1:0] pscAct;
    logic [CNT_W-1:0] phaseQ;
    logic             advance;

    // one phase step every (pscAct + 1) ticks
    assign advance        = tickEn && (divCnt == pscAct);
    assign reloadVec[ch]  = advance && (phaseQ == PHASE_LAST);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        divCnt <= '0;
        pscAct <= DEF_PSC;
        phaseQ <= '0;
      end else if (tickEn) begin
        if (advance) begin
          divCnt <= '0;
          phaseQ <= phaseQ + 1'b1;
          if (reloadVec[ch]) pscAct <= pscCfg[ch];
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end

    assign phase[ch] = phaseQ;
  end

  assign strobe.run    = runQ;
  assign strobe.reload = reloadVec;
endmodule

// File: rtl/blinkData.sv
module blinkData
  import blinkPkg::*;
#(
  parameter int NUM_LEDS = 8,
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] DEF_DUTY = 8'h80
) (
  input  logic clk,
  input  logic rstN,
  input  chanStrobe_t strobe,
  input  logic [CH_COUNT-1:0][CNT_W-1:0] phase,
  input  logic [CH_COUNT-1:0][CNT_W-1:0] dutyCfg,
  input  logic [2*NUM_LEDS-1:0] ledSel,
  input  logic [NUM_LEDS-1:0] padIn,
  output logic [NUM_LEDS-1:0] pullLow,
  output logic [NUM_LEDS-1:0] padLevel
);
  logic [CH_COUNT-1:0] chanLow;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_duty
    logic [CNT_W-1:0] dutyAct;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  dutyAct <= DEF_DUTY;
      else if (strobe.reload[ch]) dutyAct <= dutyCfg[ch];
    end

    assign chanLow[ch] = (phase[ch] < dutyAct);
  end

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    ledSrc_e src;
    logic    drive;

    assign src = ledSrc_e'(ledSel[2*i +: 2]);

    always_comb begin
      case (src)
        SEL_OFF: drive = 1'b0;
        SEL_ON:  drive = 1'b1;
        SEL_CH0: drive = chanLow[0];
        SEL_CH1: drive = chanLow[1];
        default: drive = 1'b0;
      endcase
    end

    assign pullLow[i] = strobe.run & drive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) padLevel <= '0;
    else       padLevel <= padIn;
  end
endmodule

// File: rtl/blinkDimmer.sv
module blinkDimmer
  import blinkPkg::*;
#(
  parameter int NUM_LEDS = 8,
  parameter int CNT_W = 8,
  parameter int PSC_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic [PSC_W-1:0] rate0,
  input  logic [CNT_W-1:0] duty0,
  input  logic [PSC_W-1:0] rate1,
  input  logic [CNT_W-1:0] duty1,
  input  logic [2*NUM_LEDS-1:0] ledSel,
  input  logic [NUM_LEDS-1:0] padIn,
  output logic [NUM_LEDS-1:0] pullLow,
  output logic [NUM_LEDS-1:0] padLevel
);
  localparam logic [CNT_W-1:0] DEF_DUTY = CNT_W'(1) << (CNT_W - 1);
  localparam logic [PSC_W-1:0] DEF_PSC  = '0;

  logic [CH_COUNT-1:0][PSC_W-1:0] pscCfg;
  logic [CH_COUNT-1:0][CNT_W-1:0] dutyCfg;
  logic [CH_COUNT-1:0][CNT_W-1:0] phase;
  chanStrobe_t strobe;

  assign pscCfg  = {rate1, rate0};
  assign dutyCfg = {duty1, duty0};

  blinkCtrl #(
    .PSC_W(PSC_W), .CNT_W(CNT_W), .DEF_PSC(DEF_PSC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .pscCfg(pscCfg), .phase(phase), .strobe(strobe)
  );

  blinkData #(
    .NUM_LEDS(NUM_LEDS), .CNT_W(CNT_W), .DEF_DUTY(DEF_DUTY)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phase(phase),
    .dutyCfg(dutyCfg), .ledSel(ledSel), .padIn(padIn),
    .pullLow(pullLow), .padLevel(padLevel)
  );
endmodule

// File: rtl/blinkDimmerChecker.sv
module blinkDimmerChecker #(
  parameter int NUM_LEDS = 8
) (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic [2*NUM_LEDS-1:0] ledSel,
  input logic [NUM_LEDS-1:0] padIn,
  input logic [NUM_LEDS-1:0] pullLow,
  input logic [NUM_LEDS-1:0] padLevel
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1: released pins during reset
  always @(negedge clk) begin
    if (!rstN) begin
      assert_released_R1: assert (pullLow == '0)
        else $error("pin pulled low during reset");
    end
  end

  // R2: no tick, no change
  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && !tickEn) |=> ($stable(pullLow) || !$stable(ledSel)));

  // R7: registered pad readback
  assert_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0) |=> (padLevel == $past(padIn)));

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_pin
    // R4: fixed codes
    assert_force_on_R4: assert property (@(posedge clk) disable iff (!rstN)
      (age == 2'd3 && ledSel[2*i +: 2] == 2'b01) |-> pullLow[i]);
    assert_force_off_R4: assert property (@(posedge clk) disable iff (!rstN)
      (age == 2'd3 && ledSel[2*i +: 2] == 2'b00) |-> !pullLow[i]);
    // R3: pins on the same channel agree
    assert_same_chan_R3: assert property (@(posedge clk) disable iff (!rstN)
      (age == 2'd3 && ledSel[2*i+1] && ledSel[2*i +: 2] == ledSel[1:0])
        |-> (pullLow[i] == pullLow[0]));
  end
endmodule

bind blinkDimmer blinkDimmerChecker #(.NUM_LEDS(NUM_LEDS)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .ledSel(ledSel),
  .padIn(padIn), .pullLow(pullLow), .padLevel(padLevel)
);

// File: tb/blinkDimmer_tb_top.sv
module blinkDimmer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic [7:0] rate0 = 8'h00, duty0 = 8'h80, rate1 = 8'h00, duty1 = 8'h80;
  logic [15:0] ledSel = 16'h5555;
  logic [7:0] padIn = 8'hA5;
  logic [7:0] pullLow, padLevel;

  int passCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  blinkDimmer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .rate0(rate0), .duty0(duty0), .rate1(rate1), .duty1(duty1),
    .ledSel(ledSel), .padIn(padIn), .pullLow(pullLow), .padLevel(padLevel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // samples len negedges; lit count and rising transitions per pin
  task automatic measureAll(input int len, output int onCnt[8], output int rises[8]);
    logic [7:0] prev;
    prev = pullLow;
    for (int k = 0; k < 8; k++) begin onCnt[k] = 0; rises[k] = 0; end
    repeat (len) begin
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        if (pullLow[k]) onCnt[k]++;
        if (!prev[k] && pullLow[k]) rises[k]++;
      end
      prev = pullLow;
    end
  endtask

  task automatic waitRise0(output bit found);
    logic prev;
    found = 1'b0;
    prev = pullLow[0];
    for (int k = 0; k < 4000 && !found; k++) begin
      @(negedge clk);
      if (!prev && pullLow[0]) found = 1'b1;
      prev = pullLow[0];
    end
  endtask

  // counts lit samples starting at the current one
  task automatic runLen0(output int len);
    len = 0;
    while (pullLow[0] && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    int onCnt[8];
    int rises[8];
    int prevP;
    int run1, run2;
    bit found;
    logic [1:0] codes[8];
    int exp[8];

    // reset state
    cyc(3);
    check(pullLow == 8'h00, "R1", "pins released in reset", pullLow, 0);
    rstN = 1'b1;
    cyc(2);
    check(pullLow == 8'hFF, "R4", "code 01 drives all low", pullLow, 255);
    check(padLevel == 8'hA5, "R7", "pad readback", padLevel, 8'hA5);
    padIn = 8'h3C;
    cyc(1);
    check(padLevel == 8'h3C, "R7", "pad readback one clock later", padLevel, 8'h3C);
    ledSel = 16'h0000;
    cyc(1);
    check(pullLow == 8'h00, "R4", "code 00 releases all", pullLow, 0);
    ledSel = 16'hAAAA;
    cyc(1);
    check(pullLow == 8'hFF, "R1", "cleared phase below default duty", pullLow, 255);
    measureAll(50, onCnt, rises);
    check(onCnt[0] == 50 && rises[0] == 0, "R2", "no tick holds output", onCnt[0], 50);

    // sweep rate and duty on channel 0
    tickEn = 1'b1;
    prevP = 0;
    foreach (onCnt[k]) onCnt[k] = 0;
    for (int pi = 0; pi < 3; pi++) begin
      int p;
      p = (pi == 0) ? 0 : (pi == 1) ? 1 : 3;
      for (int di = 0; di < 5; di++) begin
        int d;
        d = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 64 : (di == 3) ? 128 : 255;
        rate0 = 8'(p);
        duty0 = 8'(d);
        cyc(256 * (prevP + 1) + 4);
        prevP = p;
        measureAll(512 * (p + 1), onCnt, rises);
        check(onCnt[0] == 2 * d * (p + 1), "R3", $sformatf("lit ticks p=%0d d=%0d", p, d),
              onCnt[0], 2 * d * (p + 1));
        check(rises[0] == ((d == 0) ? 0 : 2), "R2", $sformatf("edges p=%0d d=%0d", p, d),
              rises[0], (d == 0) ? 0 : 2);
      end
    end

    // selector mapping with both channels
    rate0 = 8'd0; duty0 = 8'h40; rate1 = 8'd1; duty1 = 8'hC0;
    codes = '{2'b10, 2'b11, 2'b01, 2'b00, 2'b11, 2'b10, 2'b00, 2'b01};
    for (int k = 0; k < 8; k++) begin
      ledSel[2*k +: 2] = codes[k];
      exp[k] = (codes[k] == 2'b00) ? 0 : (codes[k] == 2'b01) ? 512 :
               (codes[k] == 2'b10) ? 2 * 64 : 192 * 2;
    end
    cyc(256 * 4 + 4);
    measureAll(512, onCnt, rises);
    for (int k = 0; k < 8; k++)
      check(onCnt[k] == exp[k], "R4", $sformatf("led %0d code %0d", k, codes[k]),
            onCnt[k], exp[k]);
    check(rises[1] == 1, "R2", "channel 1 period 512", rises[1], 1);

    // deferred duty update
    ledSel = 16'h000A;
    duty0 = 8'h30;
    cyc(600);
    waitRise0(found);
    duty0 = 8'h90;
    runLen0(run1);
    waitRise0(found);
    runLen0(run2);
    check(run1 == 8'h30, "R5", "run in progress keeps old duty", run1, 8'h30);
    check(run2 == 8'h90, "R5", "next period uses new duty", run2, 8'h90);

    // deferred rate update
    duty0 = 8'h20;
    cyc(600);
    waitRise0(found);
    rate0 = 8'd2;
    runLen0(run1);
    waitRise0(found);
    runLen0(run2);
    check(run1 == 32, "R6", "run in progress keeps old rate", run1, 32);
    check(run2 == 96, "R6", "next period uses new rate", run2, 96);

    // reset mid-run, defaults return
    rate0 = 8'd0;
    cyc(800);
    while (pullLow[0]) @(negedge clk);
    duty0 = 8'h10;
    tickEn = 1'b0;
    rstN = 1'b0;
    cyc(2);
    check(pullLow[0] == 1'b0, "R1", "pin released in reset", pullLow[0], 0);
    rstN = 1'b1;
    cyc(2);
    check(pullLow[0] == 1'b1, "R1", "phase cleared by reset", pullLow[0], 1);
    tickEn = 1'b1;
    runLen0(run1);
    waitRise0(found);
    runLen0(run2);
    check(run1 == 128, "R1", "first run uses default duty", run1, 128);
    check(run2 == 16, "R1", "duty input loaded at first wrap", run2, 16);

    done = 1'b1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end
endmodule